// File: doc/BRIEF.md
# Synthesizer Comparison and Loop-Divider Core

This block holds the digital part of a phase-locked frequency synthesizer. A fixed divider turns the crystal clock into a comparison tick. A programmable divider counts RF pulses that have already been prescaled and produces a feedback tick once every N pulses. A two-state phase/frequency detector compares the two ticks and drives the pump-up and pump-down enables of the external charge pump. A lock monitor raises a flag after the loop has stayed tight for several comparison periods.

Three test controls come from the register block. One copies both divided signals onto two probe outputs. One floats the charge pump. One switches off the varicap-drive amplifier. All logic runs on the crystal clock. The prescaled RF input is taken as a one-cycle strobe that is already in that clock domain.

Top module: `synth_loop_core`

## Requirements
- R1: The comparison tick repeats every REF_DIV crystal clocks (default 512). With `tst_route` high, `probe_ref` pulses for one cycle per tick, so consecutive probe pulses are exactly REF_DIV cycles apart.
- R2: The loop divider emits one feedback tick per N strobes on `rf_pulse`, where N is the unsigned value of `n_word`. The ratios 0 and 1 both give one tick per strobe.
- R3: A new `n_word` takes effect only at the next terminal count. A period already in progress completes with the old ratio, and the period after it uses the new one.
- R4: `pump_up` asserts when the comparison tick leads and `pump_dn` asserts when the feedback tick leads. The two are never high together. When the two ticks arrive in the same cycle, neither asserts.
- R5: While `cp_float` is high, `pump_hiz` is high and both pump enables are low, starting one cycle after `cp_float` is sampled.
- R6: `vdrive_off` follows `amp_off` with one cycle of delay.
- R7: With `tst_route` low, `probe_ref` and `probe_div` stay low. With `tst_route` high, `probe_div` pulses once per feedback tick.
- R8: `lock_flag` rises after LOCK_CYCLES (default 8) consecutive comparison ticks in which no pump pulse lasted more than LOCK_WIN (default 4) clocks.
- R9: `lock_flag` drops in the cycle after a pump pulse reaches LOCK_WIN+1 clocks, and the good-period count restarts from zero.
- R10: While `rst` is high, all outputs are low, both dividers are cleared, and the active ratio is loaded from `n_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_pulse | input | 1 | One-cycle strobe per prescaled RF period |
| n_word | input | N_BITS | Loop divider ratio |
| tst_route | input | 1 | Copy the divided signals to the probe outputs |
| cp_float | input | 1 | Float the charge pump |
| amp_off | input | 1 | Switch off the varicap-drive amplifier |
| pump_up | output | 1 | Charge-pump source enable |
| pump_dn | output | 1 | Charge-pump sink enable |
| pump_hiz | output | 1 | Charge pump floated |
| lock_flag | output | 1 | Loop in lock |
| probe_ref | output | 1 | Comparison tick on the test port |
| probe_div | output | 1 | Feedback tick on the test port |
| vdrive_off | output | 1 | Varicap-drive amplifier disable |

## Verification
The bench changes the ratio part-way through a divider period. A design that reloaded at once would produce one short, corrupted period in place of a full old-ratio period followed by the new one. Ratios 0 and 1 are driven to catch a terminal-count compare that underflows and stalls the divider for 2^15 strobes. Equal, faster and slower feedback are each run from reset. This catches a detector that lets both enables through, that shows an enable for coincident ticks, or that has the directions swapped. The lock flag is sampled just before and just after the eighth good period to catch an off-by-one in the period count. A slow drift is then applied, and the flag must drop once the pump pulses grow past the window.

// File: rtl/synth_pkg.sv
package synth_pkg;
  typedef struct packed {
    logic route;
    logic cp_float;
    logic amp_off;
  } tctl_t;
endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int unsigned DIV = 512
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned W = (DIV < 2) ? 1 : $clog2(DIV);
  localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

  logic [W-1:0] cnt;

  generate
    if (POW2) begin : g_wrap
      // power of two: free-running wrap, terminal is all ones
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt    <= '0;
          tick_o <= 1'b0;
        end else begin
          cnt    <= cnt + W'(1);
          tick_o <= (cnt == {W{1'b1}});
        end
      end
    end else begin : g_cmp
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt    <= '0;
          tick_o <= 1'b0;
        end else if (cnt == W'(DIV - 1)) begin
          cnt    <= '0;
          tick_o <= 1'b1;
        end else begin
          cnt    <= cnt + W'(1);
          tick_o <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/loop_divider.sv
module loop_divider #(
  parameter int unsigned NB = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rf_pulse,
  input  logic [NB-1:0] n_word,
  output logic          tick_o
);
  logic [NB-1:0] cnt;
  logic [NB-1:0] n_act;
  logic [NB-1:0] term;

  // ratios 0 and 1 collapse to divide-by-one
  always_comb term = (n_act <= NB'(1)) ? '0 : n_act - NB'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      n_act  <= n_word;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (rf_pulse) begin
        if (cnt == term) begin
          cnt    <= '0;
          tick_o <= 1'b1;
          n_act  <= n_word;   // reload only at terminal count
        end else begin
          cnt <= cnt + NB'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pfd.sv
module pfd (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic ref_tick,
  input  logic div_tick,
  output logic up_o,
  output logic dn_o
);
  logic nxt_up, nxt_dn, coincide;

  always_comb begin
    nxt_up   = up_o | ref_tick;
    nxt_dn   = dn_o | div_tick;
    coincide = nxt_up & nxt_dn;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_o <= nxt_up & ~coincide;
      dn_o <= nxt_dn & ~coincide;
    end
  end
endmodule

// File: rtl/lock_detector.sv
module lock_detector #(
  parameter int unsigned WIN = 4,
  parameter int unsigned CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic cmp_tick,
  output logic lock_o
);
  localparam int unsigned WW = $clog2(WIN + 1) + 1;
  localparam int unsigned GW = $clog2(CYC) + 1;

  logic [WW-1:0] wcnt;
  logic [GW-1:0] good;
  logic          wide;
  logic          over;

  // pulse has now been high for WIN+1 clocks
  always_comb over = active && (wcnt == WW'(WIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt <= '0;
    end else if (!active) begin
      wcnt <= '0;
    end else if (wcnt != WW'(WIN)) begin
      wcnt <= wcnt + WW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      good   <= '0;
      wide   <= 1'b0;
      lock_o <= 1'b0;
    end else if (over) begin
      good   <= '0;
      wide   <= 1'b1;
      lock_o <= 1'b0;
    end else if (cmp_tick) begin
      wide <= 1'b0;
      if (wide) begin
        good <= '0;
      end else if (good == GW'(CYC - 1)) begin
        lock_o <= 1'b1;
      end else begin
        good <= good + GW'(1);
      end
    end
  end
endmodule

// File: rtl/synth_loop_core.sv
module synth_loop_core #(
  parameter int unsigned REF_DIV     = 512,
  parameter int unsigned N_BITS      = 15,
  parameter int unsigned LOCK_WIN    = 4,
  parameter int unsigned LOCK_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rf_pulse,
  input  logic [N_BITS-1:0] n_word,
  input  logic              tst_route,
  input  logic              cp_float,
  input  logic              amp_off,
  output logic              pump_up,
  output logic              pump_dn,
  output logic              pump_hiz,
  output logic              lock_flag,
  output logic              probe_ref,
  output logic              probe_div,
  output logic              vdrive_off
);
  import synth_pkg::*;

  tctl_t ctl;
  logic  ref_tick, div_tick;

  always_comb ctl = '{route: tst_route, cp_float: cp_float, amp_off: amp_off};

  ref_divider #(.DIV(REF_DIV)) u_ref (
    .clk(clk), .rst(rst), .tick_o(ref_tick)
  );

  loop_divider #(.NB(N_BITS)) u_loop (
    .clk(clk), .rst(rst), .rf_pulse(rf_pulse), .n_word(n_word), .tick_o(div_tick)
  );

  pfd u_pfd (
    .clk(clk), .rst(rst), .hold(ctl.cp_float),
    .ref_tick(ref_tick), .div_tick(div_tick),
    .up_o(pump_up), .dn_o(pump_dn)
  );

  lock_detector #(.WIN(LOCK_WIN), .CYC(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst(rst), .active(pump_up | pump_dn),
    .cmp_tick(ref_tick), .lock_o(lock_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pump_hiz   <= 1'b0;
      probe_ref  <= 1'b0;
      probe_div  <= 1'b0;
      vdrive_off <= 1'b0;
    end else begin
      pump_hiz   <= ctl.cp_float;
      probe_ref  <= ctl.route & ref_tick;
      probe_div  <= ctl.route & div_tick;
      vdrive_off <= ctl.amp_off;
    end
  end
endmodule

// File: rtl/synth_loop_checker.sv
module synth_loop_checker #(
  parameter int unsigned LOCK_WIN = 4
) (
  input logic clk,
  input logic rst,
  input logic tst_route,
  input logic cp_float,
  input logic amp_off,
  input logic pump_up,
  input logic pump_dn,
  input logic pump_hiz,
  input logic lock_flag,
  input logic probe_ref,
  input logic probe_div,
  input logic vdrive_off
);
  localparam int unsigned SAT = LOCK_WIN + 3;
  localparam int unsigned CW  = $clog2(SAT + 1) + 1;

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || !(pump_up || pump_dn)) run <= '0;
    else if (run != CW'(SAT)) run <= run + CW'(1);
  end

  // R4
  a_r4_never_both: assert property (@(posedge clk) disable iff (rst)
    !(pump_up && pump_dn));

  // R5
  a_r5_hiz_quiet: assert property (@(posedge clk) disable iff (rst)
    pump_hiz |-> (!pump_up && !pump_dn));

  // R5
  a_r5_hiz_follows: assert property (@(posedge clk) disable iff (rst)
    cp_float |=> pump_hiz);

  // R6
  a_r6_vdrive_delay: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (vdrive_off == $past(amp_off)));

  // R7
  a_r7_probe_gated: assert property (@(posedge clk) disable iff (rst)
    !tst_route |=> (!probe_ref && !probe_div));

  // R9
  a_r9_wide_unlocks: assert property (@(posedge clk) disable iff (rst)
    (run > CW'(LOCK_WIN + 1)) |-> !lock_flag);
endmodule

bind synth_loop_core synth_loop_checker u_chk (
  .clk(clk), .rst(rst), .tst_route(tst_route), .cp_float(cp_float),
  .amp_off(amp_off), .pump_up(pump_up), .pump_dn(pump_dn),
  .pump_hiz(pump_hiz), .lock_flag(lock_flag), .probe_ref(probe_ref),
  .probe_div(probe_div), .vdrive_off(vdrive_off)
);

// File: tb/tb_synth_loop_core.sv
`timescale 1ns/1ps
module tb_synth_loop_core;
  localparam int NB = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rf_pulse = 1'b0;
  logic [NB-1:0] n_word = '0;
  logic          tst_route = 1'b0, cp_float = 1'b0, amp_off = 1'b0;
  logic          pump_up, pump_dn, pump_hiz, lock_flag;
  logic          probe_ref, probe_div, vdrive_off;

  int tests = 0, fails = 0;
  int cyc = 0;
  int rf_every = 1;
  int rf_ph = 0;
  bit done = 0;

  synth_loop_core dut (
    .clk(clk), .rst(rst), .rf_pulse(rf_pulse), .n_word(n_word),
    .tst_route(tst_route), .cp_float(cp_float), .amp_off(amp_off),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
    .lock_flag(lock_flag), .probe_ref(probe_ref), .probe_div(probe_div),
    .vdrive_off(vdrive_off)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // RF strobe generator, driven away from the active edge
  always @(negedge clk) begin
    if (rf_every <= 0) rf_pulse = 1'b0;
    else begin
      rf_pulse = (rf_ph == 0);
      rf_ph = (rf_ph + 1 >= rf_every) ? 0 : rf_ph + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int n, input int every);
    rst = 1'b1;
    n_word = NB'(n);
    rf_every = every;
    rf_ph = 0;
    tst_route = 1'b0; cp_float = 1'b0; amp_off = 1'b0;
    repeat (4) @(negedge clk);
    check({pump_up, pump_dn, pump_hiz, lock_flag, probe_ref, probe_div, vdrive_off} == 7'b0,
          "R10 outputs in reset",
          int'({pump_up, pump_dn, pump_hiz, lock_flag, probe_ref, probe_div, vdrive_off}), 0);
    rst = 1'b0;
  endtask

  task automatic wait_div(output int t);
    int k;
    k = 0;
    do begin @(negedge clk); k++; end while (!probe_div && k < 40000);
    t = cyc;
    if (k >= 40000) check(0, "R7 probe_div timeout", 0, 1);
  endtask

  task automatic wait_ref(output int t);
    int k;
    k = 0;
    do begin @(negedge clk); k++; end while (!probe_ref && k < 4000);
    t = cyc;
    if (k >= 4000) check(0, "R1 probe_ref timeout", 0, 1);
  endtask

  task automatic t_ref_period;
    int a, b, c;
    do_reset(100, 1);
    tst_route = 1'b1;
    wait_ref(a); wait_ref(b); wait_ref(c);
    check(b - a == 512, "R1 ref period", b - a, 512);
    check(c - b == 512, "R1 ref period 2", c - b, 512);
  endtask

  task automatic t_ratio;
    int a, b, c;
    do_reset(77, 2);
    tst_route = 1'b1;
    wait_div(a); wait_div(b); wait_div(c);
    check(b - a == 154, "R2 N=77 half rate", b - a, 154);
    check(c - b == 154, "R2 N=77 repeat", c - b, 154);
    n_word = NB'(1);
    wait_div(a); wait_div(a); wait_div(a); wait_div(b);
    check(b - a == 2, "R2 N=1", b - a, 2);
    n_word = NB'(0);
    wait_div(a); wait_div(a); wait_div(b);
    check(b - a == 2, "R2 N=0", b - a, 2);
    rf_every = 1;
    n_word = NB'(5000);
    wait_div(a); wait_div(a); wait_div(b);
    check(b - a == 5000, "R2 N=5000", b - a, 5000);
  endtask

  task automatic t_reload;
    int a, b, c;
    do_reset(300, 1);
    tst_route = 1'b1;
    wait_div(a);
    repeat (40) @(negedge clk);
    n_word = NB'(100);
    wait_div(b); wait_div(c);
    check(b - a == 300, "R3 old ratio finishes", b - a, 300);
    check(c - b == 100, "R3 new ratio next", c - b, 100);
  endtask

  task automatic t_dir(input int n, input int exp_up, input int exp_dn);
    int ups, dns;
    ups = 0; dns = 0;
    do_reset(n, 1);
    repeat (3000) begin
      @(negedge clk);
      if (pump_up) ups++;
      if (pump_dn) dns++;
    end
    if (exp_up != 0) check(ups > 0, "R4 up when ref leads", ups, 1);
    else check(ups == 0, "R4 no up", ups, 0);
    if (exp_dn != 0) check(dns > 0, "R4 dn when div leads", dns, 1);
    else check(dns == 0, "R4 no dn", dns, 0);
  endtask

  task automatic t_lock;
    int r;
    do_reset(512, 1);
    r = cyc;
    while (cyc < r + 3600) @(negedge clk);
    check(lock_flag == 1'b0, "R8 no lock before 8 periods", lock_flag, 0);
    while (cyc < r + 4400) @(negedge clk);
    check(lock_flag == 1'b1, "R8 lock after 8 periods", lock_flag, 1);
    n_word = NB'(508);
    repeat (3500) @(negedge clk);
    check(lock_flag == 1'b0, "R9 lock lost on wide pulse", lock_flag, 0);
  endtask

  task automatic t_float;
    int act;
    do_reset(400, 1);
    cp_float = 1'b1;
    @(negedge clk);
    check(pump_hiz == 1'b1, "R5 hiz one cycle later", pump_hiz, 1);
    act = 0;
    repeat (2000) begin
      @(negedge clk);
      if (pump_up || pump_dn) act++;
    end
    check(act == 0, "R5 pump quiet while floated", act, 0);
    cp_float = 1'b0;
    act = 0;
    repeat (2000) begin
      @(negedge clk);
      if (pump_dn) act++;
    end
    check(act > 0, "R5 pump resumes", act, 1);
    check(pump_hiz == 1'b0, "R5 hiz released", pump_hiz, 0);
  endtask

  task automatic t_amp;
    do_reset(100, 1);
    amp_off = 1'b1;
    @(negedge clk);
    check(vdrive_off == 1'b1, "R6 amp off", vdrive_off, 1);
    amp_off = 1'b0;
    @(negedge clk);
    check(vdrive_off == 1'b0, "R6 amp on", vdrive_off, 0);
  endtask

  task automatic t_route_off;
    int seen;
    do_reset(100, 1);
    seen = 0;
    repeat (2000) begin
      @(negedge clk);
      if (probe_ref || probe_div) seen++;
    end
    check(seen == 0, "R7 probes silent when not routed", seen, 0);
  endtask

  initial begin
    t_ref_period();
    t_ratio();
    t_reload();
    t_dir(400, 0, 1);
    t_dir(600, 1, 0);
    t_dir(512, 0, 0);
    t_lock();
    t_float();
    t_amp();
    t_route_off();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule